// File: doc/BRIEF.md
# Offload Hazard Queue

This block sits beside a core's local load/store path and remembers the accesses the core has handed to a second load/store unit further down its pipeline. Each handed-off access leaves a short address tag and a write flag in a small in-order queue. The entry stays there until the downstream unit reports that the access is complete. While an entry is pending, the core's own later loads and stores are checked against every pending entry. A request that could overtake a pending access is held back.

The direction of the local request decides what counts as a hazard. A local store waits on any pending access that carries the same tag. A local load waits only on a pending store that carries the same tag. Tags are a slice of the word address, so two different words can share a tag. Such a false match costs a stall but never produces a wrong result.

The local request is offered to the memory path only when the lookup reports no hazard. The core's request is accepted when the memory path takes it. The push port applies backpressure when the queue is full. The completion strobe has no backpressure.

Top module: `offload_hazard_queue`

## Requirements
- R1: After the synchronous active-high reset the queue is empty: `push_ready` is 1, and any local request is passed on (`mem_valid` equals `loc_valid`, `loc_ready` equals `mem_ready`).
- R2: A push is taken when `push_valid` and `push_ready` are both 1. After DEPTH pushes with no completion, `push_ready` is 0 until a completion arrives.
- R3: When a completion strobe arrives while the queue is full, `push_ready` is 1 in that same cycle. A push in that cycle is taken as well, and the queue stays full.
- R4: A local store (`loc_write`=1) is held back if any pending entry has the same tag, whatever that entry's write flag is.
- R5: A local load (`loc_write`=0) is held back only if a pending entry with the same tag has its write flag set to 1. A matching pending load does not hold it back.
- R6: The tag is address bits [OFF_W+TAG_W-1:OFF_W], with OFF_W = log2(DATA_BYTES). With the defaults these are bits [10:3]. Address bits outside this slice take no part in the comparison, so aliased addresses are held back too.
- R7: Entries retire oldest first, one per `pop_strobe`. After a completion, the hazard of the oldest entry is gone and the hazards of all younger entries remain.
- R8: `mem_valid` = `loc_valid` and no hazard. `loc_ready` = `mem_ready` and no hazard. A held-back request reaches neither side.
- R9: The lookup compares against the entries pending at the start of the cycle. A push affects lookups from the next cycle on. An entry whose completion arrives in a cycle still blocks in that cycle and stops blocking in the next.
- R10: Completions are never backpressured. The number of completions must not exceed the number of pushes, and a strobe while the queue is empty is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | An access is being handed downstream |
| push_ready | output | 1 | Queue can take the handed-off access |
| push_addr | input | ADDR_W | Byte address of the handed-off access |
| push_write | input | 1 | Handed-off access is a store |
| pop_strobe | input | 1 | Downstream unit completed its oldest access |
| loc_valid | input | 1 | Core presents a local load or store |
| loc_ready | output | 1 | Local request accepted this cycle |
| loc_addr | input | ADDR_W | Byte address of the local request |
| loc_write | input | 1 | Local request is a store |
| mem_valid | output | 1 | Local request offered to the memory path |
| mem_ready | input | 1 | Memory path takes the request |

## Verification
The three outputs are combinational, so each result is due in the same cycle as the stimulus. Each result depends on the entries held at the start of that cycle. The bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. Only after that rising edge does its reference queue take the push and the completion it just applied. As a result, a push becomes visible to the lookup exactly one cycle later, and an entry being retired still blocks in its own cycle, as R9 requires.

// File: rtl/hq_pkg.sv
package hq_pkg;

  typedef enum logic [1:0] {
    HQ_EMPTY   = 2'd0,
    HQ_PARTIAL = 2'd1,
    HQ_FULL    = 2'd2
  } hq_level_e;

  function automatic int unsigned hq_ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/hq_fifo_ctrl.sv
module hq_fifo_ctrl
  import hq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = hq_ptr_width(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop,
  output logic             push_ready,
  output logic             push_go,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output hq_level_e        level
);

  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] wr_q, rd_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    if (count_q == '0)                 level = HQ_EMPTY;
    else if (count_q == CNT_W'(DEPTH)) level = HQ_FULL;
    else                               level = HQ_PARTIAL;
  end

  // A completion in the same cycle frees a slot for the push.
  assign push_ready = (level != HQ_FULL) | pop;
  assign push_go    = push_req & push_ready;
  assign wr_ptr     = wr_q;
  assign rd_ptr     = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else begin
      if (push_go) wr_q <= ptr_next(wr_q);
      if (pop)     rd_q <= ptr_next(rd_q);
      case ({push_go, pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R10
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_W'(DEPTH) && !pop) |=> (count_q == CNT_W'(DEPTH)));

  // R3
  full_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (push_go && pop) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/hq_entry_array.sv
module hq_entry_array
  import hq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned PTR_W = hq_ptr_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_go,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             push_wr,
  input  logic             pop,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             look_wr,
  output logic             collide
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] wbit_q;
  logic [DEPTH-1:0] hit;
  logic [TAG_W-1:0] tag_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel_wr, sel_rd;
    assign sel_wr = push_go & (wr_ptr == PTR_W'(i));
    assign sel_rd = pop & (rd_ptr == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        tag_q[i]  <= push_tag;
        wbit_q[i] <= push_wr;
      end
    end

    // Push wins when a full queue recycles the slot being retired.
    always_ff @(posedge clk) begin
      if (rst)         vld_q[i] <= 1'b0;
      else if (sel_wr) vld_q[i] <= 1'b1;
      else if (sel_rd) vld_q[i] <= 1'b0;
    end

    // A store conflicts with any match; a load conflicts only with a pending store.
    assign hit[i] = vld_q[i] & (tag_q[i] == look_tag) & (look_wr | wbit_q[i]);
  end

  assign collide = |hit;

  // R9
  retired_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !(push_go && wr_ptr == rd_ptr)) |=> !vld_q[$past(rd_ptr)]);

  // R7
  pushed_slot_held_chk: assert property (@(posedge clk) disable iff (rst)
    push_go |=> vld_q[$past(wr_ptr)]);

endmodule

// File: rtl/hq_gate.sv
module hq_gate (
  input  logic clk,
  input  logic rst,
  input  logic loc_valid,
  input  logic collide,
  input  logic mem_ready,
  output logic loc_ready,
  output logic mem_valid
);

  logic clear;
  assign clear     = ~collide;
  assign mem_valid = loc_valid & clear;
  assign loc_ready = mem_ready & clear;

  // R8
  stall_blocks_mem_chk: assert property (@(posedge clk) disable iff (rst)
    collide |-> (!mem_valid && !loc_ready));

endmodule

// File: rtl/offload_hazard_queue.sv
module offload_hazard_queue
  import hq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned TAG_W      = 8,
  localparam int unsigned OFF_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 0,
  localparam int unsigned PTR_W = hq_ptr_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              push_write,
  input  logic              pop_strobe,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_write,
  output logic              mem_valid,
  input  logic              mem_ready
);

  logic             push_go, collide;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  hq_level_e        level;
  logic [TAG_W-1:0] push_tag, look_tag;

  assign push_tag = push_addr[OFF_W +: TAG_W];
  assign look_tag = loc_addr[OFF_W +: TAG_W];

  hq_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .push_req   (push_valid),
    .pop        (pop_strobe),
    .push_ready (push_ready),
    .push_go    (push_go),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .level      (level)
  );

  hq_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .push_go  (push_go),
    .wr_ptr   (wr_ptr),
    .push_tag (push_tag),
    .push_wr  (push_write),
    .pop      (pop_strobe),
    .rd_ptr   (rd_ptr),
    .look_tag (look_tag),
    .look_wr  (loc_write),
    .collide  (collide)
  );

  hq_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .loc_valid (loc_valid),
    .collide   (collide),
    .mem_ready (mem_ready),
    .loc_ready (loc_ready),
    .mem_valid (mem_valid)
  );

  // R1
  empty_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (level == HQ_EMPTY) |-> (mem_valid == loc_valid && loc_ready == mem_ready));

endmodule

// File: tb/tb_offload_hazard_queue.sv
`timescale 1ns/1ps
module tb_offload_hazard_queue;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned TAG_W = 8;
  localparam int unsigned OFF_W = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0, push_write = 1'b0, pop_strobe = 1'b0;
  logic [31:0] push_addr = '0, loc_addr = '0;
  logic        loc_valid = 1'b0, loc_write = 1'b0, mem_ready = 1'b0;
  logic        push_ready, loc_ready, mem_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [TAG_W-1:0] m_tag [DEPTH];
  logic             m_wr  [DEPTH];
  int               m_cnt = 0;

  always #2 clk = ~clk;

  offload_hazard_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_addr(push_addr), .push_write(push_write),
    .pop_strobe(pop_strobe),
    .loc_valid(loc_valid), .loc_ready(loc_ready),
    .loc_addr(loc_addr), .loc_write(loc_write),
    .mem_valid(mem_valid), .mem_ready(mem_ready)
  );

  function automatic logic [TAG_W-1:0] tag_of(input logic [31:0] a);
    return a[OFF_W +: TAG_W];
  endfunction

  function automatic logic model_conflict(input logic [31:0] a, input logic w);
    logic c = 1'b0;
    for (int i = 0; i < m_cnt; i++)
      if (m_tag[i] == tag_of(a) && (w || m_wr[i])) c = 1'b1;
    return c;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [TAG_W-1:0] t);
    logic [31:0] r = $urandom;
    r[OFF_W +: TAG_W] = t;
    return r;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One cycle: drive, check the same-cycle outputs, then advance the model.
  task automatic step(input logic pv, input logic [31:0] pa, input logic pw,
                      input logic pp, input logic lv, input logic [31:0] la,
                      input logic lw, input logic mr, input string req);
    logic e_pr, e_col;
    push_valid = pv; push_addr = pa; push_write = pw; pop_strobe = pp;
    loc_valid = lv; loc_addr = la; loc_write = lw; mem_ready = mr;
    #1;
    e_pr  = (m_cnt < DEPTH) || pp;
    e_col = model_conflict(la, lw);
    check({req, " push_ready"}, push_ready, e_pr);
    check({req, " loc_ready"},  loc_ready,  mr && !e_col);
    check({req, " mem_valid"},  mem_valid,  lv && !e_col);
    @(posedge clk);
    if (pp && m_cnt > 0) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_tag[i] = m_tag[i+1];
        m_wr[i]  = m_wr[i+1];
      end
      m_cnt--;
    end
    if (pv && e_pr) begin
      m_tag[m_cnt] = tag_of(pa);
      m_wr[m_cnt]  = pw;
      m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    while (m_cnt > 0) step(0, '0, 0, 1, 0, '0, 0, 1, "R10 drain");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    step(0, '0, 0, 0, 1, mk_addr(8'h11), 1, 1, "R1 reset store");
    step(0, '0, 0, 0, 1, mk_addr(8'h11), 0, 0, "R1 reset load");

    // R2 fill to full, then the push port closes
    for (int i = 0; i < DEPTH; i++)
      step(1, mk_addr(TAG_W'(8'h20 + i)), 0, 0, 0, '0, 0, 1, "R2 fill");
    step(1, mk_addr(8'h40), 1, 0, 0, '0, 0, 1, "R2 full blocks push");
    check("R2 occupancy", m_cnt == DEPTH, 1'b1);

    // R5 load vs pending load: no stall; R4 store vs pending load: stall
    step(0, '0, 0, 0, 1, mk_addr(8'h21), 0, 1, "R5 load after load");
    step(0, '0, 0, 0, 1, mk_addr(8'h21), 1, 1, "R4 store after load");

    // R3 full + completion + push in the same cycle
    step(1, mk_addr(8'h50), 1, 1, 0, '0, 0, 1, "R3 swap while full");
    check("R3 still full", m_cnt == DEPTH, 1'b1);

    // R7 oldest (0x20) gone, younger 0x21 still held, new store 0x50 blocks a load
    step(0, '0, 0, 0, 1, mk_addr(8'h20), 1, 1, "R7 oldest retired");
    step(0, '0, 0, 0, 1, mk_addr(8'h21), 1, 1, "R7 younger kept");
    step(0, '0, 0, 0, 1, mk_addr(8'h50), 0, 1, "R5 load after store");
    drain();
    check("R10 drained", m_cnt == 0, 1'b1);

    // R9 push visible only from next cycle; retiring entry still blocks
    step(1, mk_addr(8'h05), 1, 0, 1, mk_addr(8'h05), 0, 1, "R9 same cycle push");
    step(0, '0, 0, 0, 1, mk_addr(8'h05), 0, 1, "R9 next cycle");
    step(0, '0, 0, 1, 1, mk_addr(8'h05), 0, 1, "R9 retiring still blocks");
    step(0, '0, 0, 0, 1, mk_addr(8'h05), 0, 1, "R9 after retire");

    // R6 aliasing: same tag slice, other bits differ -> stall; bit 3 differs -> clear
    step(1, 32'h0000_0028, 1, 0, 0, '0, 0, 1, "R6 setup");
    step(0, '0, 0, 0, 1, 32'hABCD_F02F, 0, 1, "R6 alias stalls");
    step(0, '0, 0, 0, 1, 32'h0000_0020, 1, 1, "R6 bit3 differs");
    step(0, '0, 0, 0, 1, 32'h0000_0828, 1, 0, "R6 above slice ignored");
    drain();

    // Random mix with a small tag pool for frequent collisions
    for (int n = 0; n < 3000; n++) begin
      logic pp, lw;
      pp = (m_cnt > 0) && ($urandom % 3 == 0);
      lw = $urandom % 2;
      step($urandom % 2, mk_addr(TAG_W'($urandom % 4)), $urandom % 2, pp,
           $urandom % 2, mk_addr(TAG_W'($urandom % 4)), lw, $urandom % 4 != 0,
           lw ? "R4 R8 random" : "R5 R8 random");
    end
    drain();
    step(0, '0, 0, 0, 1, mk_addr(8'h02), 1, 1, "R10 empty after random");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule